// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Arithmetic and Logic Unit

This block computes one arithmetic or logical operation between a 16-bit accumulator value and a 16-bit operand. It supports add, add with carry, subtract, subtract with borrow, and the bitwise AND, OR and XOR. It takes the current flag byte as an input and returns the new one. Each operation updates only the flags it defines. Every other flag bit passes through unchanged.

The result and the new flags are produced combinationally. When an operation is presented with its valid strobe, the block also raises a write enable, and on the next clock it captures the result and flags into an internal accumulator register and flag register. The surrounding core fetches operands, decodes instructions, and chooses whether to feed the registered accumulator back as the next accumulator input.

Top module: `acc16_alu`

## Requirements
- R1: The flag byte bit positions are fixed: S=bit 7, Z=bit 6, spare=bit 5, H=bit 4, X=bit 3, V=bit 2, N=bit 1, C=bit 0. The spare bit 5 always passes from `flags_i` to `flags_o` unchanged. The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 no operation.
- R2: For codes 0 to 6, S equals bit 15 of the result, and Z is 1 exactly when the 16-bit result is zero.
- R3: Add returns acc+opnd modulo 2^16. It sets both C and X to the carry out of bit 15. It sets V when the carry into bit 15 differs from the carry out of bit 15. It clears N and keeps H.
- R4: Add with carry returns acc+opnd+C. It applies the add flag rules to the full sum, so an operand of 0xFFFF with C=1 reports C=X=1 and V=0.
- R5: Subtract returns acc-opnd. It sets N. It sets V when the signed difference falls outside -32768..32767. It sets both C and X to the unsigned borrow, and it keeps H.
- R6: Subtract with borrow returns acc-(opnd+C), where opnd+C is taken at 17 bits. It sets C to the unsigned borrow. It sets H when the low 12 bits of acc are below the low 12 bits of opnd plus C (taken at 13 bits). It sets V on signed overflow and N to 1, and it keeps X.
- R7: AND sets H to 1, while OR and XOR set H to 0. All three clear N, C and X and keep V.
- R8: With `op_valid_i` high and codes 0 to 6, `wr_en_o` is high, and on the next rising clock `acc_q_o` and `flags_q_o` take the values of `res_o` and `flags_o`.
- R9: Code 7 gives `res_o`=`acc_i` and `flags_o`=`flags_i`. Code 7, or `op_valid_i` low, keeps `wr_en_o` low, and `acc_q_o` and `flags_q_o` hold.
- R10: While `rst_n` is low, `acc_q_o` and `flags_q_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_sel_i | input | 3 | Operation code |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Operand |
| flags_i | input | 8 | Current flag byte |
| res_o | output | 16 | Combinational result |
| flags_o | output | 8 | Combinational new flag byte |
| wr_en_o | output | 1 | Result is written this cycle |
| acc_q_o | output | 16 | Registered accumulator |
| flags_q_o | output | 8 | Registered flag byte |

## Verification
The bench targets the carry edges. For add with carry on an operand of 0xFFFF with C=1, a 16-bit operand-plus-carry would drop the carry and report no carry. For subtract with borrow, the same operand must show a full borrow. A low 12 bits of 0xFFF with C=1 must raise H, and a 12-bit truncated half-borrow would miss it. Signed overflow is checked at 0x7FFF+1 and 0x8000-1, which exposes a V taken from the wrong carry. The bench also verifies that X is kept by subtract with borrow, that H is kept by add and subtract, and that the no-operation code and a low valid leave the registers untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_NOP = 3'd7
   } alu_op_e;

   localparam int FLAG_W = 8;
   localparam int FL_C   = 0;
   localparam int FL_N   = 1;
   localparam int FL_V   = 2;
   localparam int FL_X   = 3;
   localparam int FL_H   = 4;
   localparam int FL_SP  = 5;
   localparam int FL_Z   = 6;
   localparam int FL_S   = 7;
endpackage

// File: rtl/acc_alu_arith.sv
// Segmented adder: low segment ends at the half-borrow boundary, middle
// segment ends below the sign bit, so carries c_half, c_sign and c_out fall out.
module acc_alu_arith #(
   parameter int DATA_W   = 16,
   parameter int HALF_POS = 12
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              inv_b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              c_half_o,
   output logic              c_sign_o,
   output logic              c_out_o
);
   localparam int MID_W = DATA_W - 1 - HALF_POS;

   if (HALF_POS < 1 || MID_W < 1) begin : g_bad_split
      $error("acc_alu_arith: HALF_POS must lie inside the low DATA_W-1 bits");
   end

   logic [DATA_W-1:0]   bx;
   logic [HALF_POS:0]   lo_sum;
   logic [MID_W:0]      mid_sum;
   logic [1:0]          top_sum;

   assign bx = inv_b_i ? ~b_i : b_i;

   assign lo_sum  = {1'b0, a_i[HALF_POS-1:0]} + {1'b0, bx[HALF_POS-1:0]}
                  + {{HALF_POS{1'b0}}, cin_i};
   assign mid_sum = {1'b0, a_i[DATA_W-2:HALF_POS]} + {1'b0, bx[DATA_W-2:HALF_POS]}
                  + {{MID_W{1'b0}}, lo_sum[HALF_POS]};
   assign top_sum = {1'b0, a_i[DATA_W-1]} + {1'b0, bx[DATA_W-1]}
                  + {1'b0, mid_sum[MID_W]};

   assign sum_o    = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[HALF_POS-1:0]};
   assign c_half_o = lo_sum[HALF_POS];
   assign c_sign_o = mid_sum[MID_W];
   assign c_out_o  = top_sum[1];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [1:0]        fn_i,   // 0 and, 1 or, 2 xor
   output logic [DATA_W-1:0] res_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign res_o[i] = (fn_i == 2'd0) ? (a_i[i] & b_i[i]) :
                        (fn_i == 2'd1) ? (a_i[i] | b_i[i]) :
                                         (a_i[i] ^ b_i[i]);
   end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              c_half_i,
   input  logic              c_sign_i,
   input  logic              c_out_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o
);
   logic ovf;
   assign ovf = c_sign_i ^ c_out_i;

   always_comb begin
      flags_o = flags_i;
      unique case (op_i)
         OP_ADD, OP_ADC: begin
            flags_o[FL_C] = c_out_i;
            flags_o[FL_X] = c_out_i;
            flags_o[FL_V] = ovf;
            flags_o[FL_N] = 1'b0;
         end
         OP_SUB: begin
            flags_o[FL_C] = ~c_out_i;
            flags_o[FL_X] = ~c_out_i;
            flags_o[FL_V] = ovf;
            flags_o[FL_N] = 1'b1;
         end
         OP_SBC: begin
            flags_o[FL_C] = ~c_out_i;
            flags_o[FL_H] = ~c_half_i;
            flags_o[FL_V] = ovf;
            flags_o[FL_N] = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            flags_o[FL_H] = (op_i == OP_AND);
            flags_o[FL_N] = 1'b0;
            flags_o[FL_C] = 1'b0;
            flags_o[FL_X] = 1'b0;
         end
         default: ;
      endcase
      if (op_i != OP_NOP) begin
         flags_o[FL_S] = res_i[DATA_W-1];
         flags_o[FL_Z] = (res_i == '0);
      end
   end
endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALF_POS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [2:0]        op_sel_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [7:0]        flags_i,
   output logic [DATA_W-1:0] res_o,
   output logic [7:0]        flags_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] acc_q_o,
   output logic [7:0]        flags_q_o
);
   if (FLAG_W != 8) begin : g_bad_flag_w
      $error("acc16_alu: flag byte must be 8 bits");
   end

   alu_op_e           op;
   logic              is_sub, is_arith, cin;
   logic [DATA_W-1:0] sum, lres;
   logic              c_half, c_sign, c_out;

   assign op       = alu_op_e'(op_sel_i);
   assign is_arith = (op_sel_i[2] == 1'b0);
   assign is_sub   = (op == OP_SUB) || (op == OP_SBC);

   always_comb begin
      unique case (op)
         OP_ADC:  cin = flags_i[FL_C];
         OP_SUB:  cin = 1'b1;
         OP_SBC:  cin = ~flags_i[FL_C];
         default: cin = 1'b0;
      endcase
   end

   acc_alu_arith #(.DATA_W(DATA_W), .HALF_POS(HALF_POS)) arith_i (
      .a_i      (acc_i),
      .b_i      (opnd_i),
      .inv_b_i  (is_sub),
      .cin_i    (cin),
      .sum_o    (sum),
      .c_half_o (c_half),
      .c_sign_o (c_sign),
      .c_out_o  (c_out)
   );

   acc_alu_logic #(.DATA_W(DATA_W)) logic_i (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .fn_i  (op_sel_i[1:0]),
      .res_o (lres)
   );

   assign res_o = is_arith       ? sum   :
                  (op == OP_NOP) ? acc_i : lres;

   acc_alu_flags #(.DATA_W(DATA_W)) flags_i_u (
      .op_i     (op),
      .res_i    (res_o),
      .c_half_i (c_half),
      .c_sign_i (c_sign),
      .c_out_i  (c_out),
      .flags_i  (flags_i),
      .flags_o  (flags_o)
   );

   assign wr_en_o = op_valid_i && (op != OP_NOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q_o   <= '0;
         flags_q_o <= '0;
      end else if (wr_en_o) begin
         acc_q_o   <= res_o;
         flags_q_o <= flags_o;
      end
   end
endmodule

// File: rtl/acc16_alu_chk.sv
module acc16_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_sel_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [7:0]        flags_i,
   input logic [DATA_W-1:0] res_o,
   input logic [7:0]        flags_o,
   input logic              wr_en_o,
   input logic [DATA_W-1:0] acc_q_o,
   input logic [7:0]        flags_q_o
);
   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (acc_q_o == $past(res_o)) && (flags_q_o == $past(flags_o)));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_o |=> $stable(acc_q_o) && $stable(flags_q_o));

   a_r9_nop_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i == 3'd7) |-> (res_o == acc_i) && (flags_o == flags_i) && !wr_en_o);

   a_r1_spare_kept: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FL_SP] == flags_i[FL_SP]);

   a_r2_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i != 3'd7) |-> (flags_o[FL_S] == res_o[DATA_W-1])
                             && (flags_o[FL_Z] == (res_o == '0)));

   a_r3_add_keeps_h: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i == 3'd0) |-> (flags_o[FL_H] == flags_i[FL_H]) && !flags_o[FL_N]
                             && (flags_o[FL_C] == flags_o[FL_X]));

   a_r5_sub_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i == 3'd2) |-> flags_o[FL_N] && (flags_o[FL_H] == flags_i[FL_H]));

   a_r6_sbc_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i == 3'd3) |-> (flags_o[FL_X] == flags_i[FL_X]) && flags_o[FL_N]);

   a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel_i[2] && op_sel_i != 3'd7) |->
         !flags_o[FL_N] && !flags_o[FL_C] && !flags_o[FL_X]
         && (flags_o[FL_V] == flags_i[FL_V]) && (flags_o[FL_H] == (op_sel_i == 3'd4)));
endmodule

bind acc16_alu acc16_alu_chk #(.DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_sel_i  (op_sel_i),
   .acc_i     (acc_i),
   .flags_i   (flags_i),
   .res_o     (res_o),
   .flags_o   (flags_o),
   .wr_en_o   (wr_en_o),
   .acc_q_o   (acc_q_o),
   .flags_q_o (flags_q_o)
);

// File: tb/acc16_alu_tb_top.sv
module acc16_alu_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [2:0]  op_sel_i = 3'd7;
   logic [15:0] acc_i = '0, opnd_i = '0;
   logic [7:0]  flags_i = '0;
   logic [15:0] res_o, acc_q_o;
   logic [7:0]  flags_o, flags_q_o;
   logic        wr_en_o;

   int checks = 0;
   int failures = 0;
   logic [15:0] exp_acc = '0;
   logic [7:0]  exp_flg = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc16_alu dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_sel_i(op_sel_i),
      .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i), .res_o(res_o),
      .flags_o(flags_o), .wr_en_o(wr_en_o), .acc_q_o(acc_q_o), .flags_q_o(flags_q_o)
   );

   // Returns {result, flags}; flag bits S7 Z6 sp5 H4 X3 V2 N1 C0.
   function automatic logic [23:0] model(input logic [2:0] op, input logic [15:0] a,
                                         input logic [15:0] b, input logic [7:0] f);
      logic [7:0] nf;
      logic [15:0] r;
      int ua, ub, cc, s, sd;
      nf = f; ua = a; ub = b; r = a;
      sd = 0; s = 0; cc = 0;
      case (op)
         3'd0, 3'd1: begin
            cc = (op == 3'd1) ? int'(f[0]) : 0;
            s = ua + ub + cc;
            r = s[15:0];
            nf[0] = (s > 65535);
            nf[3] = nf[0];
            nf[2] = nf[0] ^ (((ua & 32767) + (ub & 32767) + cc) > 32767);
            nf[1] = 1'b0;
         end
         3'd2, 3'd3: begin
            cc = (op == 3'd3) ? int'(f[0]) : 0;
            sd = int'($signed(a)) - int'($signed(b)) - cc;
            s = ua - ub - cc;
            r = s[15:0];
            nf[2] = (sd < -32768) || (sd > 32767);
            nf[0] = (ua < ub + cc);
            nf[1] = 1'b1;
            if (op == 3'd2) nf[3] = nf[0];
            else            nf[4] = ((ua & 4095) < ((ub & 4095) + cc));
         end
         3'd4, 3'd5, 3'd6: begin
            r = (op == 3'd4) ? (a & b) : (op == 3'd5) ? (a | b) : (a ^ b);
            nf[4] = (op == 3'd4);
            nf[1] = 1'b0; nf[0] = 1'b0; nf[3] = 1'b0;
         end
         default: ;
      endcase
      if (op != 3'd7) begin
         nf[7] = r[15];
         nf[6] = (r == 16'h0);
      end
      return {r, nf};
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input string req, input logic v, input logic [2:0] op,
                         input logic [15:0] a, input logic [15:0] b, input logic [7:0] f);
      logic [23:0] m;
      @(negedge clk);
      op_valid_i = v; op_sel_i = op; acc_i = a; opnd_i = b; flags_i = f;
      m = model(op, a, b, f);
      #1;
      check(req, "result", {16'h0, res_o}, {16'h0, m[23:8]});
      check(req, "flags", {24'h0, flags_o}, {24'h0, m[7:0]});
      check(req, "wr_en", {31'h0, wr_en_o}, {31'h0, v && (op != 3'd7)});
      if (v && op != 3'd7) begin
         exp_acc = m[23:8];
         exp_flg = m[7:0];
      end
      @(posedge clk);
      #1;
      check(req, "acc_q", {16'h0, acc_q_o}, {16'h0, exp_acc});
      check(req, "flags_q", {24'h0, flags_q_o}, {24'h0, exp_flg});
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5EED_1234));
      #(CLK_PERIOD * 2 + 3);
      // R10 reset state
      check("R10", "acc_q reset", {16'h0, acc_q_o}, 32'h0);
      check("R10", "flags_q reset", {24'h0, flags_q_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 signed overflow and carry edges
      run_op("R3", 1'b1, 3'd0, 16'h7FFF, 16'h0001, 8'h10);
      run_op("R3", 1'b1, 3'd0, 16'hFFFF, 16'h0001, 8'h00);
      // R4 operand 0xFFFF with carry in
      run_op("R4", 1'b1, 3'd1, 16'h1234, 16'hFFFF, 8'h01);
      run_op("R4", 1'b1, 3'd1, 16'h7FFF, 16'h0000, 8'h01);
      // R5 borrow and signed overflow
      run_op("R5", 1'b1, 3'd2, 16'h0000, 16'h0001, 8'h10);
      run_op("R5", 1'b1, 3'd2, 16'h8000, 16'h0001, 8'h00);
      // R6 half borrow at 0xFFF plus carry, full borrow, X kept
      run_op("R6", 1'b1, 3'd3, 16'h1000, 16'h0FFF, 8'h09);
      run_op("R6", 1'b1, 3'd3, 16'h4321, 16'hFFFF, 8'h01);
      run_op("R6", 1'b1, 3'd3, 16'h0005, 16'h0003, 8'h00);
      // R7 logical flag rules
      run_op("R7", 1'b1, 3'd4, 16'hF0F0, 16'h0F0F, 8'h0F);
      run_op("R7", 1'b1, 3'd5, 16'h8000, 16'h0001, 8'h1D);
      run_op("R7", 1'b1, 3'd6, 16'hAAAA, 16'hAAAA, 8'h14);
      // R1 spare bit kept
      run_op("R1", 1'b1, 3'd0, 16'h0001, 16'h0002, 8'h20);
      // R9 no operation and valid low hold the registers
      run_op("R9", 1'b1, 3'd7, 16'hBEEF, 16'h1111, 8'hA5);
      run_op("R9", 1'b0, 3'd2, 16'h0100, 16'h0001, 8'h00);

      // R2 R8 random mix, sometimes chaining the registered accumulator
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [2:0]  op;
         a  = ($urandom_range(0, 3) == 0) ? acc_q_o : 16'($urandom);
         op = 3'($urandom_range(0, 7));
         run_op("R8", ($urandom_range(0, 7) != 0), op, a, 16'($urandom), 8'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule